// File: doc/BRIEF.md
# Serial IRQ device encoder

This block sits in a peripheral on a shared, open-drain serialized interrupt line that is clocked by the bus clock. Up to fifteen internal interrupt sources each carry a configured IRQ number from 1 to 15; the value 0 turns a source off. The block watches the line for start frames from the host. After a start frame it pulls the line low in the time slot that belongs to each active IRQ number. The number reaches the host only through the clock position of that low pulse.

A frame's data phase is sixteen slots of three clocks each, so it spans 48 clocks. Frame clock 0 is the first clock in which the line is high after the start frame. Slot n covers frame clocks 3n to 3n+2. A stop frame follows, and its length selects the operating mode for later frames.

In continuous mode the host starts every frame. In quiet mode the device may begin a start frame on its own when a new request appears. It drives one low clock, and the host then stretches that clock into a full start frame. The only output is an open-drain enable: when it is high, the line is pulled low. The block never drives the line high.

Top module: `serirq_dev_encoder`

## Requirements
- R1: After reset the drive enable is low and the block is in continuous mode, so a new request does not make it drive the line.
- R2: A start frame is a run of 4 to 8 consecutive low clocks followed by a high clock. A low run of 3 or of 9 clocks starts no frame, and no slot is driven after it.
- R3: For an active IRQ number n, the drive enable is high in frame clock 3n only, for exactly one clock, and low in every other data-phase clock.
- R4: Several sources with different IRQ numbers are all reported in the same frame. Two sources with the same number produce one pulse in that slot.
- R5: A source that is deasserted, or that is asserted with IRQ number 0, never drives the line.
- R6: The set of reported slots is captured in the clock where the start frame ends. Request changes during the data phase do not affect that frame.
- R7: An asserted source is reported again in every frame until it is deasserted. After that it no longer appears.
- R8: A stop frame of 2 low clocks selects quiet mode, and one of 3 low clocks selects continuous mode. Any other stop length leaves the mode unchanged.
- R9: In quiet mode, when the block is idle and the line is high, a newly asserted active source makes the block drive the line low for exactly one clock. This happens two clocks after the request appears, and a host-stretched start frame then carries that request's slot.
- R10: In continuous mode the block never starts a frame. Its drive enable stays low outside the data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Request level of each interrupt source |
| src_irq | input | NUM_SRC*IRQ_W | IRQ number of each source; source i uses bits [i*IRQ_W +: IRQ_W], and 0 means disabled |
| serirq_in | input | 1 | Sampled level of the shared line |
| serirq_oe | output | 1 | Open-drain enable; 1 pulls the line low |

## Verification
The assertions assume the line input is the wired-AND of host and device drive, sampled in the bus clock domain. They also assume the host sends a stop frame after every 48-clock data phase and never holds the line low inside that phase except where the device drives it. The bench models the wire as the inverse of the OR of the host's pull-down and the drive enable. It drives host pulses only in the start and stop windows, and it changes source settings on the falling clock edge, so every sample at a rising edge sees stable levels.

// File: rtl/serirq_pkg.sv
// Shared types and protocol constants for the serial IRQ device encoder.
// Assumes a three-clock slot (sample, recovery, turnaround).
package serirq_pkg;
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_STOP = 2'd2
    } frame_st_t;

    localparam int unsigned SLOT_LEN = 3;
endpackage

// File: rtl/serirq_slot_map.sv
// Converts per-source request/IRQ-number pairs into a one-hot-per-slot
// active mask. Assumes IRQ number 0 means disabled; bit 0 stays low.
module serirq_slot_map #(
    parameter int NUM_SRC = 15,
    parameter int IRQ_W   = 4,
    localparam int NUM_SLOTS = 1 << IRQ_W
) (
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*IRQ_W-1:0] src_irq,
    output logic [NUM_SLOTS-1:0]     act_mask
);
    logic [NUM_SLOTS-1:0] hot [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [IRQ_W-1:0] num;
        assign num = src_irq[g*IRQ_W +: IRQ_W];
        // per-source decode of its IRQ number into a slot bit
        always_comb begin
            hot[g] = '0;
            if (src_req[g] && num != '0) hot[g][num] = 1'b1;
        end
    end

    // merge all sources into one mask; equal numbers collapse to one bit
    always_comb begin
        act_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) act_mask = act_mask | hot[i];
    end
endmodule

// File: rtl/serirq_frame_track.sv
// Follows the shared line: counts low runs, recognises start frames,
// walks the slot/phase position during the data phase and decodes the
// stop frame length into the quiet/continuous mode flag.
// Assumes the host issues a stop frame after every data phase.
module serirq_frame_track
    import serirq_pkg::*;
#(
    parameter int IRQ_W     = 4,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8,
    localparam int NUM_SLOTS = 1 << IRQ_W,
    localparam int RUN_W     = $clog2(START_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output frame_st_t        st,
    output logic [IRQ_W-1:0] sl,
    output logic [1:0]       ph,
    output logic [RUN_W-1:0] low_run,
    output logic             start_pulse,
    output logic             quiet_mode
);
    localparam logic [IRQ_W-1:0] LAST_SL = IRQ_W'(NUM_SLOTS - 1);
    localparam logic [1:0]       LAST_PH = 2'(SLOT_LEN - 1);

    // count consecutive low clocks, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (line_in)        low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 1'b1;
    end

    assign start_pulse = (st == FR_IDLE) && line_in &&
                         (low_run >= RUN_W'(START_MIN)) &&
                         (low_run <= RUN_W'(START_MAX));

    // frame state, slot position and mode flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FR_IDLE;
            sl         <= '0;
            ph         <= '0;
            quiet_mode <= 1'b0;
        end else begin
            unique case (st)
                FR_IDLE: if (start_pulse) begin
                    st <= FR_DATA;
                    sl <= '0;
                    ph <= 2'd1;
                end
                FR_DATA: if (ph == LAST_PH) begin
                    ph <= '0;
                    if (sl == LAST_SL) st <= FR_STOP;
                    else               sl <= sl + 1'b1;
                end else begin
                    ph <= ph + 1'b1;
                end
                FR_STOP: if (line_in && low_run != '0) begin
                    st <= FR_IDLE;
                    if (low_run == RUN_W'(2))      quiet_mode <= 1'b1;
                    else if (low_run == RUN_W'(3)) quiet_mode <= 1'b0;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_STOP && line_in && low_run == RUN_W'(2)) |=> quiet_mode);
    // R8
    stop_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_STOP && line_in && low_run == RUN_W'(3)) |=> !quiet_mode);
    // R2
    long_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_IDLE && line_in && low_run > RUN_W'(START_MAX)) |=> st == FR_IDLE);
endmodule

// File: rtl/serirq_drive.sv
// Produces the registered open-drain enable: one low clock in the first
// clock of each captured active slot, plus the single-clock device start
// pulse in quiet mode. Assumes inputs from serirq_frame_track.
module serirq_drive
    import serirq_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int RUN_W = 4,
    localparam int NUM_SLOTS = 1 << IRQ_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] act_mask,
    input  frame_st_t            st,
    input  logic [IRQ_W-1:0]     sl,
    input  logic [1:0]           ph,
    input  logic [RUN_W-1:0]     low_run,
    input  logic                 start_pulse,
    input  logic                 quiet_mode,
    input  logic                 line_in,
    output logic                 oe
);
    localparam logic [IRQ_W-1:0] LAST_SL = IRQ_W'(NUM_SLOTS - 1);
    localparam logic [1:0]       LAST_PH = 2'(SLOT_LEN - 1);

    logic [NUM_SLOTS-1:0] mask_q, act_prev;
    logic                 quiet_req, new_req, slot_drive, init_drive;
    logic [IRQ_W-1:0]     next_sl;

    assign new_req    = |(act_mask & ~act_prev);
    assign next_sl    = sl + 1'b1;
    assign slot_drive = (st == FR_DATA) && (ph == LAST_PH) &&
                        (sl != LAST_SL) && mask_q[next_sl];
    assign init_drive = (st == FR_IDLE) && quiet_mode && quiet_req &&
                        line_in && (low_run == '0) && !oe;

    // capture the mask at frame start and remember last mask for edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            act_prev <= '0;
        end else begin
            act_prev <= act_mask;
            if (start_pulse) mask_q <= act_mask;
        end
    end

    // pending device-start request, quiet mode only
    always_ff @(posedge clk) begin
        if (!rst_n)                        quiet_req <= 1'b0;
        else if (start_pulse || init_drive) quiet_req <= 1'b0;
        else if (quiet_mode && new_req)    quiet_req <= 1'b1;
    end

    // registered drive enable for the next clock
    always_ff @(posedge clk) begin
        if (!rst_n) oe <= 1'b0;
        else        oe <= slot_drive | init_drive;
    end

    // R3
    slot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && st == FR_DATA) |-> (ph == 2'd0 && sl != '0));
    // R9
    one_clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && st == FR_IDLE) |=> !oe);
    // R10
    cont_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != FR_DATA && !quiet_mode) |-> !oe);
    // R3
    stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_STOP) |-> !oe);
endmodule

// File: rtl/serirq_dev_encoder.sv
// Top of the device-side serial IRQ encoder: slot map, line tracker and
// drive stage. Assumes serirq_in is synchronous to clk.
module serirq_dev_encoder
    import serirq_pkg::*;
#(
    parameter int NUM_SRC   = 15,
    parameter int IRQ_W     = 4,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*IRQ_W-1:0] src_irq,
    input  logic                     serirq_in,
    output logic                     serirq_oe
);
    localparam int NUM_SLOTS = 1 << IRQ_W;
    localparam int RUN_W     = $clog2(START_MAX + 2);

    logic [NUM_SLOTS-1:0] act_mask;
    frame_st_t            st;
    logic [IRQ_W-1:0]     sl;
    logic [1:0]           ph;
    logic [RUN_W-1:0]     low_run;
    logic                 start_pulse, quiet_mode;

    serirq_slot_map #(.NUM_SRC(NUM_SRC), .IRQ_W(IRQ_W)) u_map (
        .src_req (src_req),
        .src_irq (src_irq),
        .act_mask(act_mask)
    );

    serirq_frame_track #(.IRQ_W(IRQ_W), .START_MIN(START_MIN),
                         .START_MAX(START_MAX)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (serirq_in),
        .st         (st),
        .sl         (sl),
        .ph         (ph),
        .low_run    (low_run),
        .start_pulse(start_pulse),
        .quiet_mode (quiet_mode)
    );

    serirq_drive #(.IRQ_W(IRQ_W), .RUN_W(RUN_W)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_mask   (act_mask),
        .st         (st),
        .sl         (sl),
        .ph         (ph),
        .low_run    (low_run),
        .start_pulse(start_pulse),
        .quiet_mode (quiet_mode),
        .line_in    (serirq_in),
        .oe         (serirq_oe)
    );
endmodule

// File: tb/serirq_dev_encoder_test.sv
// Directed bench: a host model pulls the wired line, tasks per scenario.
module serirq_dev_encoder_test;
    localparam int NUM_SRC = 15;
    localparam int IRQ_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_SRC-1:0]       src_req = '0;
    logic [NUM_SRC*IRQ_W-1:0] src_irq = '0;
    logic host_low = 1'b0;
    logic serirq_oe;
    logic serirq_in;
    int n_chk = 0;
    int n_bad = 0;

    assign serirq_in = ~(host_low | serirq_oe);

    always #4 clk = ~clk;

    serirq_dev_encoder #(.NUM_SRC(NUM_SRC), .IRQ_W(IRQ_W)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_irq(src_irq),
        .serirq_in(serirq_in), .serirq_oe(serirq_oe)
    );

    task automatic chk(input logic act, input logic exp, input string req,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic set_src(input int i, input int irq, input logic req);
        src_irq[i*IRQ_W +: IRQ_W] = IRQ_W'(irq);
        src_req[i] = req;
    endtask

    // data phase check plus stop frame; optional mid-frame request change
    task automatic data_and_stop(input logic [15:0] exp, input int stop_len,
                                 input string req, input bit mid,
                                 input logic [NUM_SRC-1:0] mid_req);
        host_low = 1'b0;
        for (int k = 0; k < 48; k++) begin
            if (mid && k == 2) src_req = mid_req;
            chk(serirq_oe, (k % 3 == 0) && exp[k/3], req, $sformatf("frame clk %0d", k));
            @(negedge clk);
        end
        host_low = 1'b1;
        repeat (stop_len) @(negedge clk);
        host_low = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input int start_len, input int stop_len,
                             input logic [15:0] exp, input string req);
        host_low = 1'b1;
        repeat (start_len) @(negedge clk);
        data_and_stop(exp, stop_len, req, 1'b0, '0);
    endtask

    task automatic t_reset;
        chk(serirq_oe, 1'b0, "R1", "oe after reset");
        set_src(0, 5, 1'b1);
        repeat (6) begin
            @(negedge clk);
            chk(serirq_oe, 1'b0, "R1", "no self start after reset");
        end
        set_src(0, 5, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_single;
        set_src(0, 5, 1'b1);
        run_frame(4, 3, 16'h0020, "R3");
        set_src(0, 5, 1'b0);
    endtask

    task automatic t_multi;
        set_src(1, 1, 1'b1);
        set_src(2, 15, 1'b1);
        set_src(3, 15, 1'b1);
        set_src(4, 0, 1'b1);   // R5 number zero
        set_src(5, 7, 1'b0);   // R5 deasserted
        run_frame(8, 3, 16'h8002, "R4");
        run_frame(6, 3, 16'h8002, "R7");
        set_src(1, 1, 1'b0);
        run_frame(5, 3, 16'h8000, "R7");
        src_req = '0;
        run_frame(4, 3, 16'h0000, "R5");
    endtask

    task automatic t_bad_start;
        set_src(0, 5, 1'b1);
        host_low = 1'b1;
        repeat (3) @(negedge clk);
        data_and_stop(16'h0000, 0, "R2", 1'b0, '0);
        host_low = 1'b1;
        repeat (9) @(negedge clk);
        data_and_stop(16'h0000, 0, "R2", 1'b0, '0);
        set_src(0, 5, 1'b0);
    endtask

    task automatic t_snapshot;
        set_src(6, 4, 1'b1);
        set_src(7, 9, 1'b0);
        host_low = 1'b1;
        repeat (5) @(negedge clk);
        data_and_stop(16'h0010, 3, "R6", 1'b1, 15'h0080);
        run_frame(4, 3, 16'h0200, "R6");
        src_req = '0;
    endtask

    // device start in quiet mode, host stretches, frame follows
    task automatic quiet_start(input int i, input int irq, input logic [15:0] exp,
                               input int stop_len);
        set_src(i, irq, 1'b1);
        @(negedge clk);
        chk(serirq_oe, 1'b0, "R9", "quiet start one clock later");
        @(negedge clk);
        chk(serirq_oe, 1'b1, "R9", "quiet start pulse");
        host_low = 1'b1;
        @(negedge clk);
        chk(serirq_oe, 1'b0, "R9", "quiet start single clock");
        repeat (3) @(negedge clk);
        data_and_stop(exp, stop_len, "R9", 1'b0, '0);
    endtask

    task automatic t_modes;
        src_req = '0;
        run_frame(4, 2, 16'h0000, "R8");
        quiet_start(8, 3, 16'h0008, 4);
        quiet_start(9, 12, 16'h1008, 3);
        src_req = '0;
        @(negedge clk);
        set_src(10, 6, 1'b1);
        repeat (6) begin
            @(negedge clk);
            chk(serirq_oe, 1'b0, "R10", "continuous no self start");
        end
        src_req = '0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_bad_start();
        t_snapshot();
        t_modes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule